// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block sits between two chained 8-line interrupt controllers and the processor's acknowledge cycle. It holds the request and in-service bits of both controllers. When an acknowledge is accepted, it decides which controller supplies the vector and updates those bits. It returns an 8-bit vector, made from the programmed base with its low three bits replaced by the line number, and a global line number from 0 to 15. Priority resolution inside each controller happens outside the block. It arrives as a "winner valid + line" pair per controller, computed from the request and in-service bits that this block exposes.

The slave controller is chained into master line 2. Whenever the slave has a winning request, the block sends a one-cycle pulse into master line 2, which latches as an edge on that line. An acknowledge that lands on master line 2 goes down into the slave. If a controller that should supply the vector has no winner, a spurious line-7 vector is returned.

The acknowledge input is a valid/ready stream. A request is taken on a cycle where `ack_valid` and `ack_ready` are both high, and `ack_valid` may stay high while `ack_ready` is low. The result is not back-pressured: `ack_done` is high for one cycle and `ack_vec`/`ack_line` are valid only in that cycle. The cycle that follows every accepted acknowledge is a re-evaluation cycle (`reeval` high). During it `ack_ready` is low, so the external priority logic sees the updated bits before the next acknowledge is taken.

Top module: `cas_ack_seq`

## Requirements
- R1: After reset, all request and in-service bits are 0, `ack_done`, `reeval` and `cas_pulse` are 0, `ack_vec` and `ack_line` are 0, and `ack_ready` is 1.
- R2: On an accepted acknowledge where the master winner is a line L other than 2, master in-service bit L is set. The next cycle shows `ack_vec` = (master base AND 0xF8) OR L and `ack_line` = L.
- R3: An acknowledge clears the acknowledged request bit when that line is edge-triggered (its `level_mode` bit is 0). It leaves the request bit set when the line is level-triggered (bit 1). `level_mode` bit 8+k belongs to slave line k.
- R4: When the master winner is line 2 and the slave has a winner S, the block sets master in-service bit 2 and slave in-service bit S, updates both request bits per R3, and returns `ack_vec` = (slave base AND 0xF8) OR S and `ack_line` = 8+S.
- R5: When the master winner is line 2 and the slave has no winner, the block returns `ack_vec` = (slave base AND 0xF8) OR 7 and `ack_line` = 15. Slave bits are unchanged; master line 2 is still acknowledged.
- R6: When the master has no winner, the block returns `ack_vec` = (master base AND 0xF8) OR 7 and `ack_line` = 7. No request or in-service bit changes as a result of the acknowledge.
- R7: The low three bits of either base input have no effect on `ack_vec`.
- R8: A cycle with `s_win_valid` high makes `cas_pulse` high in the next cycle unless `cas_pulse` is already high, so the pulse never lasts two cycles. A cycle with `cas_pulse` high sets master request bit 2 at the following edge.
- R9: `ack_done` is high for exactly one cycle per accepted acknowledge, in the cycle after acceptance. In every other cycle `ack_vec` and `ack_line` read 0.
- R10: `reeval` is high in the cycle after every accepted acknowledge, and `ack_ready` is low in exactly that cycle. A held `ack_valid` is therefore accepted at most every second cycle.
- R11: `irq_set` bit n sets request bit n at the next edge, and `irq_clr` bit n clears it. Bits 0-7 belong to the master and 8-15 to the slave. A set wins over a clear, and over an acknowledge clear, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_valid | input | 1 | Acknowledge request |
| ack_ready | output | 1 | Acknowledge can be taken this cycle |
| m_win_valid | input | 1 | Master has a winning line |
| m_win_line | input | 3 | Master winning line |
| s_win_valid | input | 1 | Slave has a winning line |
| s_win_line | input | 3 | Slave winning line |
| m_base | input | 8 | Master vector base |
| s_base | input | 8 | Slave vector base |
| level_mode | input | 16 | Per-line level-trigger select (1 = level) |
| irq_set | input | 16 | Request-bit set pulses |
| irq_clr | input | 16 | Request-bit clear pulses |
| ack_done | output | 1 | One-cycle acknowledge result strobe |
| ack_vec | output | 8 | Returned vector |
| ack_line | output | 4 | Global line number 0-15 |
| reeval | output | 1 | Re-evaluation cycle after an acknowledge |
| cas_pulse | output | 1 | Slave-to-master line 2 pulse |
| m_irr | output | 8 | Master request bits |
| m_isr | output | 8 | Master in-service bits |
| s_irr | output | 8 | Slave request bits |
| s_isr | output | 8 | Slave in-service bits |

## Verification
The bench targets the cascade branches. A design that skipped the slave on master line 2 would return the master base with line 2. One that mishandled the slave-empty case would change slave bits or report line 7 instead of 15. The bench also holds `ack_valid` high across the re-evaluation cycle: a sequencer without the hold-off would emit back-to-back done strobes from stale winners. Level-triggered lines, same-cycle set/clear collisions and base inputs with their low bits set are exercised as well. A wrong trigger-mode test, a wrong collision priority or an unmasked base shows up directly in the request bits or the vector.

// File: rtl/cas_ack_pkg.sv
package cas_ack_pkg;

  typedef enum logic [1:0] {
    KIND_MASTER      = 2'd0,
    KIND_SLAVE       = 2'd1,
    KIND_SLAVE_SPUR  = 2'd2,
    KIND_MASTER_SPUR = 2'd3
  } ack_kind_e;

endpackage

// File: rtl/cas_ack_resolve.sv
module cas_ack_resolve
  import cas_ack_pkg::*;
#(
  parameter int LW        = 3,
  parameter int VEC_W     = 8,
  parameter int CAS_LINE  = 2,
  parameter int SPUR_LINE = 7
) (
  input  logic             m_hit,
  input  logic [LW-1:0]    m_line,
  input  logic             s_hit,
  input  logic [LW-1:0]    s_line,
  input  logic [VEC_W-1:0] m_base,
  input  logic [VEC_W-1:0] s_base,
  output ack_kind_e        kind,
  output logic             m_ack,
  output logic             s_ack,
  output logic [VEC_W-1:0] vec,
  output logic [LW:0]      gline
);

  localparam logic [LW-1:0] CASL = LW'(CAS_LINE);
  localparam logic [LW-1:0] SPUR = LW'(SPUR_LINE);

  logic [VEC_W-LW-1:0] m_hi, s_hi;
  assign m_hi = m_base[VEC_W-1:LW];
  assign s_hi = s_base[VEC_W-1:LW];

  always_comb begin
    if (!m_hit)               kind = KIND_MASTER_SPUR;
    else if (m_line != CASL)  kind = KIND_MASTER;
    else if (s_hit)           kind = KIND_SLAVE;
    else                      kind = KIND_SLAVE_SPUR;
  end

  always_comb begin
    m_ack = 1'b0;
    s_ack = 1'b0;
    vec   = '0;
    gline = '0;
    unique case (kind)
      KIND_MASTER: begin
        m_ack = 1'b1;
        vec   = {m_hi, m_line};
        gline = {1'b0, m_line};
      end
      KIND_SLAVE: begin
        m_ack = 1'b1;
        s_ack = 1'b1;
        vec   = {s_hi, s_line};
        gline = {1'b1, s_line};
      end
      KIND_SLAVE_SPUR: begin
        m_ack = 1'b1;
        vec   = {s_hi, SPUR};
        gline = {1'b1, SPUR};
      end
      default: begin
        vec   = {m_hi, SPUR};
        gline = {1'b0, SPUR};
      end
    endcase
  end

endmodule

// File: rtl/cas_ctrl_bits.sv
module cas_ctrl_bits #(
  parameter int LINES = 8,
  parameter int LW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] set_req,
  input  logic [LINES-1:0] clr_req,
  input  logic [LINES-1:0] level,
  input  logic             ack_en,
  input  logic [LW-1:0]    ack_line,
  output logic [LINES-1:0] irr,
  output logic [LINES-1:0] isr
);

  logic [LINES-1:0] ack_hot;
  logic [LINES-1:0] ack_drop;

  always_comb begin
    ack_hot = '0;
    if (ack_en) ack_hot[ack_line] = 1'b1;
    ack_drop = ack_hot & ~level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
    end else begin
      irr <= (irr & ~clr_req & ~ack_drop) | set_req;
      isr <= isr | ack_hot;
    end
  end

  assert_isr_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |=> isr[$past(ack_line)]);

  assert_level_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && level[ack_line] && irr[ack_line] && !clr_req[ack_line])
      |=> irr[$past(ack_line)]);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req != '0) |=> ((irr & $past(set_req)) == $past(set_req)));

endmodule

// File: rtl/cas_ack_seq.sv
module cas_ack_seq
  import cas_ack_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int VEC_W     = 8,
  parameter int CAS_LINE  = 2,
  parameter int SPUR_LINE = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ack_valid,
  output logic                  ack_ready,
  input  logic                  m_win_valid,
  input  logic [$clog2(LINES)-1:0] m_win_line,
  input  logic                  s_win_valid,
  input  logic [$clog2(LINES)-1:0] s_win_line,
  input  logic [VEC_W-1:0]      m_base,
  input  logic [VEC_W-1:0]      s_base,
  input  logic [2*LINES-1:0]    level_mode,
  input  logic [2*LINES-1:0]    irq_set,
  input  logic [2*LINES-1:0]    irq_clr,
  output logic                  ack_done,
  output logic [VEC_W-1:0]      ack_vec,
  output logic [$clog2(LINES):0] ack_line,
  output logic                  reeval,
  output logic                  cas_pulse,
  output logic [LINES-1:0]      m_irr,
  output logic [LINES-1:0]      m_isr,
  output logic [LINES-1:0]      s_irr,
  output logic [LINES-1:0]      s_isr
);

  localparam int LW    = $clog2(LINES);
  localparam int NCTRL = 2;

  logic                    busy_q, done_q, cas_q;
  logic [VEC_W-1:0]        vec_q;
  logic [LW:0]             gline_q;
  logic                    ack_go;

  ack_kind_e               kind;
  logic                    m_ack, s_ack;
  logic [VEC_W-1:0]        vec_n;
  logic [LW:0]             gline_n;

  logic [NCTRL-1:0][LINES-1:0] set_v, clr_v, lvl_v, irr_v, isr_v;
  logic [NCTRL-1:0]            ack_en_v;
  logic [NCTRL-1:0][LW-1:0]    ack_ln_v;

  assign ack_ready = !busy_q;
  assign ack_go    = ack_valid && !busy_q;

  cas_ack_resolve #(
    .LW(LW), .VEC_W(VEC_W), .CAS_LINE(CAS_LINE), .SPUR_LINE(SPUR_LINE)
  ) u_resolve (
    .m_hit (m_win_valid),
    .m_line(m_win_line),
    .s_hit (s_win_valid),
    .s_line(s_win_line),
    .m_base(m_base),
    .s_base(s_base),
    .kind  (kind),
    .m_ack (m_ack),
    .s_ack (s_ack),
    .vec   (vec_n),
    .gline (gline_n)
  );

  for (genvar gi = 0; gi < NCTRL; gi++) begin : g_ctrl
    logic [LINES-1:0] cas_in;
    always_comb begin
      cas_in = '0;
      if (gi == 0) cas_in[CAS_LINE] = cas_q;
    end
    assign set_v[gi]    = irq_set[gi*LINES +: LINES] | cas_in;
    assign clr_v[gi]    = irq_clr[gi*LINES +: LINES];
    assign lvl_v[gi]    = level_mode[gi*LINES +: LINES];
    assign ack_en_v[gi] = ack_go && ((gi == 0) ? m_ack : s_ack);
    assign ack_ln_v[gi] = (gi == 0) ? m_win_line : s_win_line;

    cas_ctrl_bits #(.LINES(LINES), .LW(LW)) u_bits (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (set_v[gi]),
      .clr_req (clr_v[gi]),
      .level   (lvl_v[gi]),
      .ack_en  (ack_en_v[gi]),
      .ack_line(ack_ln_v[gi]),
      .irr     (irr_v[gi]),
      .isr     (isr_v[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cas_q   <= 1'b0;
      vec_q   <= '0;
      gline_q <= '0;
    end else begin
      busy_q  <= ack_go;
      done_q  <= ack_go;
      cas_q   <= s_win_valid && !cas_q;
      vec_q   <= ack_go ? vec_n   : '0;
      gline_q <= ack_go ? gline_n : '0;
    end
  end

  assign ack_done  = done_q;
  assign ack_vec   = vec_q;
  assign ack_line  = gline_q;
  assign reeval    = busy_q;
  assign cas_pulse = cas_q;
  assign m_irr     = irr_v[0];
  assign m_isr     = isr_v[0];
  assign s_irr     = irr_v[1];
  assign s_isr     = isr_v[1];

  assert_cas_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cas_pulse |=> !cas_pulse);

  assert_cas_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cas_pulse |=> m_irr[CAS_LINE]);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_done |=> !ack_done);

  assert_quiet_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_done |-> (ack_vec == '0 && ack_line == '0));

  assert_holdoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready) |=> (reeval && !ack_ready));

  assert_spur_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready && !m_win_valid) |=> (ack_line == LW'(SPUR_LINE)));

endmodule

// File: tb/sim_cas_ack_seq.sv
module sim_cas_ack_seq;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_valid = 1'b0;
  logic        ack_ready;
  logic        m_win_valid = 1'b0;
  logic [2:0]  m_win_line = '0;
  logic        s_win_valid = 1'b0;
  logic [2:0]  s_win_line = '0;
  logic [7:0]  m_base = '0;
  logic [7:0]  s_base = '0;
  logic [15:0] level_mode = '0;
  logic [15:0] irq_set = '0;
  logic [15:0] irq_clr = '0;
  logic        ack_done, reeval, cas_pulse;
  logic [7:0]  ack_vec, m_irr, m_isr, s_irr, s_isr;
  logic [3:0]  ack_line;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit chk_en  = 0;

  // reference state
  logic [7:0] e_mirr, e_misr, e_sirr, e_sisr, e_vec;
  logic [3:0] e_line;
  logic       e_done, e_busy, e_cas;
  string      e_tag = "R2";

  always #(CLK_P/2) clk = ~clk;

  cas_ack_seq u0 (
    .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .m_win_valid(m_win_valid), .m_win_line(m_win_line),
    .s_win_valid(s_win_valid), .s_win_line(s_win_line),
    .m_base(m_base), .s_base(s_base), .level_mode(level_mode),
    .irq_set(irq_set), .irq_clr(irq_clr), .ack_done(ack_done),
    .ack_vec(ack_vec), .ack_line(ack_line), .reeval(reeval),
    .cas_pulse(cas_pulse), .m_irr(m_irr), .m_isr(m_isr),
    .s_irr(s_irr), .s_isr(s_isr)
  );

  function automatic logic [7:0] mk_vec(input logic [7:0] base, input logic [2:0] ln);
    return (base & 8'hF8) | {5'd0, ln};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      e_mirr = 0; e_misr = 0; e_sirr = 0; e_sisr = 0;
      e_vec = 0; e_line = 0; e_done = 0; e_busy = 0; e_cas = 0;
    end else begin
      logic acc;
      logic [7:0] mset, mdrop, mins, sdrop, sins, v;
      logic [3:0] gl;
      acc = ack_valid && !e_busy;
      mset = irq_set[7:0] | (e_cas ? 8'h04 : 8'h00);
      mdrop = 0; mins = 0; sdrop = 0; sins = 0; v = 0; gl = 0;
      if (acc) begin
        if (!m_win_valid) begin
          v = mk_vec(m_base, 3'd7); gl = 4'd7; e_tag = "R6";
        end else begin
          mins[m_win_line] = 1'b1;
          if (!level_mode[m_win_line]) mdrop[m_win_line] = 1'b1;
          if (m_win_line != 3'd2) begin
            v = mk_vec(m_base, m_win_line); gl = {1'b0, m_win_line}; e_tag = "R2";
          end else if (s_win_valid) begin
            sins[s_win_line] = 1'b1;
            if (!level_mode[8 + s_win_line]) sdrop[s_win_line] = 1'b1;
            v = mk_vec(s_base, s_win_line); gl = 4'd8 + {1'b0, s_win_line}; e_tag = "R4";
          end else begin
            v = mk_vec(s_base, 3'd7); gl = 4'd15; e_tag = "R5";
          end
        end
      end
      e_mirr = (e_mirr & ~irq_clr[7:0] & ~mdrop) | mset;
      e_sirr = (e_sirr & ~irq_clr[15:8] & ~sdrop) | irq_set[15:8];
      e_misr = e_misr | mins;
      e_sisr = e_sisr | sins;
      e_cas  = s_win_valid && !e_cas;
      e_done = acc;
      e_busy = acc;
      e_vec  = v;
      e_line = gl;
    end
  end

  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      check("R9 done", ack_done, e_done);
      check({e_tag, " R7 vec"}, ack_vec, e_vec);
      check({e_tag, " line"}, ack_line, e_line);
      check("R10 reeval", reeval, e_busy);
      check("R10 ready", ack_ready, !e_busy);
      check("R8 cas", cas_pulse, e_cas);
      check("R3 R11 m_irr", m_irr, e_mirr);
      check("R3 R11 s_irr", s_irr, e_sirr);
      check("R2 m_isr", m_isr, e_misr);
      check("R4 s_isr", s_isr, e_sisr);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ack_valid = 0; irq_set = 0; irq_clr = 0; s_win_valid = 0; m_win_valid = 0;
    end
  endtask

  task automatic do_ack(input logic mv, input logic [2:0] ml, input logic sv, input logic [2:0] sl);
    @(negedge clk);
    irq_set = 0; irq_clr = 0;
    ack_valid = 1; m_win_valid = mv; m_win_line = ml; s_win_valid = sv; s_win_line = sl;
    @(negedge clk);
    ack_valid = 0; m_win_valid = 0; s_win_valid = 0;
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", ack_ready, 1); check("R1 done", ack_done, 0);
    check("R1 vec", ack_vec, 0); check("R1 line", ack_line, 0);
    check("R1 reeval", reeval, 0); check("R1 cas", cas_pulse, 0);
    check("R1 bits", {m_irr, m_isr, s_irr, s_isr}, 0);
    chk_en = 1;

    // R7 and R2: base with low bits set, master line 3
    m_base = 8'h27; s_base = 8'h7D;
    do_ack(1, 3'd3, 0, 3'd0);
    check("R7 vec low bits ignored", ack_vec, 8'h23);
    check("R2 line", ack_line, 4'd3);
    idle(1);

    // R3 level vs edge
    level_mode = 16'h0020;
    @(negedge clk); irq_set = 16'h0030;
    idle(1);
    do_ack(1, 3'd5, 0, 3'd0);
    idle(1);
    check("R3 level kept", m_irr[5], 1'b1);
    do_ack(1, 3'd4, 0, 3'd0);
    idle(1);
    check("R3 edge cleared", m_irr[4], 1'b0);

    // R11 set beats clear
    @(negedge clk); irq_set = 16'h0100; irq_clr = 16'h0120;
    idle(1);
    check("R11 set wins", s_irr[0], 1'b1);
    check("R11 clear", m_irr[5], 1'b0);

    // R4 slave ack, R5 slave spurious, R6 master spurious
    do_ack(1, 3'd2, 1, 3'd6);
    check("R4 vec", ack_vec, 8'h7E); check("R4 line", ack_line, 4'd14);
    idle(1);
    do_ack(1, 3'd2, 0, 3'd1);
    check("R5 vec", ack_vec, 8'h7F); check("R5 line", ack_line, 4'd15);
    idle(1);
    do_ack(0, 3'd1, 1, 3'd1);
    check("R6 vec", ack_vec, 8'h27); check("R6 line", ack_line, 4'd7);
    idle(2);

    // R10 held valid: done on alternate cycles
    @(negedge clk); ack_valid = 1; m_win_valid = 1; m_win_line = 3'd1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R10 alternating done", ack_done, (i % 2 == 0));
    end
    idle(2);

    // R8 cascade pulse alternates
    @(negedge clk); s_win_valid = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 pulse", cas_pulse, (i % 2 == 0));
    end
    idle(2);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ack_valid   = ($urandom % 3) == 0;
      m_win_valid = ($urandom % 5) != 0;
      m_win_line  = ($urandom % 3 == 0) ? 3'd2 : 3'($urandom);
      s_win_valid = $urandom % 2;
      s_win_line  = 3'($urandom);
      irq_set     = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
      irq_clr     = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
      if ($urandom % 50 == 0) begin
        level_mode = 16'($urandom);
        m_base = 8'($urandom); s_base = 8'($urandom);
      end
    end
    idle(3);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule